// File: doc/BRIEF.md
# Serial Memory Command Engine

This block is the slave-side protocol engine of a serial memory with a 131,072-byte array. It watches the serial clock, the active-low select, and the serial data input, all sampled in the system clock domain. It frames each transaction on the select line and shifts in an 8-bit opcode and a 24-bit address. It then runs one of four commands:

- sequential read
- write enable
- write
- read status

Read data comes from a synchronous byte-array port with one cycle of latency. Incoming write bytes go out on a byte-write strobe to a page buffer in a separate block. A commit request hands the finished page to that block, and the block reports completion on `commit_done`.

The engine owns two flags: the write-enable latch (WEL) and the busy flag. While a commit is running, it refuses every command except status read.

The controller uses these states:

- **IDLE**: the select line is high.
- **OPCODE**: shifting in the command byte.
- **ADDR**: shifting in the address.
- **RD_DATA**: streaming array bytes.
- **ST_DATA**: streaming the status byte.
- **WR_DATA**: taking in write bytes.
- **WREN_WAIT**: a write enable is waiting for deselect.
- **IGNORE**: the rest of the transaction is discarded.

The transitions are:

- Select high forces IDLE from any state.
- A select falling edge moves IDLE to OPCODE.
- The 8th opcode bit leaves OPCODE for ADDR, WREN_WAIT, ST_DATA or IGNORE.
- The 24th address bit leaves ADDR for RD_DATA or WR_DATA.

Top module: `memcmd_engine`

## Requirements
- R1: After reset, `so_oe`, `mem_rd_en`, `mem_wr_en` and `commit_req` are 0, and a status read returns 0x00.
- R2: `so_oe` is 1 while the synchronised select is low and 0 while it is high.
- R3: Opcode 0x03 followed by a 3-byte address returns the array byte at the low 17 address bits, MSB first on `so`. The upper 7 address bits and any `si` data after the address are ignored.
- R4: A read streams successive bytes for as long as select stays low. The address goes from 0x1FFFF to 0x00000.
- R5: Opcode 0x06 sets WEL when select rises, provided no commit is running.
- R6: Opcode 0x05 returns the status byte {6'b0, WEL (bit 1), busy (bit 0)}, repeated for every following byte while select stays low.
- R7: With WEL set, opcode 0x02, an address and data bytes produce one `mem_wr_en` pulse per whole byte. Address bits [6:0] count up and wrap within the 128-byte page; bits [16:7] stay fixed.
- R8: A select rise in a write after at least one whole byte, with no partial byte pending, pulses `commit_req` for one cycle and sets busy.
- R9: `commit_done` while busy clears both busy and WEL.
- R10: Opcode 0x02 without WEL writes nothing and requests no commit.
- R11: While busy, any opcode other than 0x05 starts no array read and no write.
- R12: An unknown opcode makes the engine ignore every later byte until select rises. The next transaction is decoded normally.
- R13: A select rise in the middle of a write byte discards that partial byte. No commit is requested and WEL stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock (mode 0) |
| cs_n | input | 1 | Active-low select |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for `so` |
| mem_rd_en | output | 1 | Array read strobe |
| mem_addr | output | 17 | Array address for reads and writes |
| mem_rd_data | input | 8 | Array read data, valid one cycle after the strobe |
| mem_wr_en | output | 1 | Byte strobe to the page buffer |
| mem_wr_data | output | 8 | Byte to the page buffer |
| commit_req | output | 1 | One-cycle request to commit the page |
| commit_done | input | 1 | Commit finished |

## Verification
A wrong flag shows up at the ports quickly.

- **Stuck WEL or busy:** the byte reported by the next status read is wrong, within one byte time of that read.
- **Write accepted without WEL or while busy:** a byte-write strobe appears roughly three system clocks after the eighth data bit.
- **Address counter errors:** a wrong wrap or page carry shows up either as a wrong byte on `so` one byte later, or as a mismatched address on the next write strobe.
- **Stale state after an ignored command:** it is caught in the next transaction, which would be decoded wrongly.

// File: rtl/memcmd_pkg.sv
package memcmd_pkg;

    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_WRITE = 8'h02;
    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_RDSR  = 8'h05;

    typedef enum logic [2:0] {
        S_IDLE,
        S_OPCODE,
        S_ADDR,
        S_RD_DATA,
        S_ST_DATA,
        S_WR_DATA,
        S_WREN_WAIT,
        S_IGNORE
    } eng_state_t;

endpackage

// File: rtl/memcmd_sync.sv
module memcmd_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic si,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_rise,
    output logic cs_fall,
    output logic cs_lvl,
    output logic si_s
);

    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES:0]   sck_p;
    logic [SYNC_STAGES:0]   cs_p;
    logic [SYNC_STAGES-1:0] si_p;

    // stage LAST is the stable sample, stage SYNC_STAGES the one before it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_p <= '0;
            cs_p  <= '1;
            si_p  <= '0;
        end else begin
            sck_p <= {sck_p[SYNC_STAGES-1:0], sck};
            cs_p  <= {cs_p[SYNC_STAGES-1:0], cs_n};
            si_p  <= {si_p[SYNC_STAGES-2:0], si};
        end
    end

    assign sck_rise = sck_p[LAST] & ~sck_p[SYNC_STAGES];
    assign sck_fall = ~sck_p[LAST] & sck_p[SYNC_STAGES];
    assign cs_rise  = cs_p[LAST] & ~cs_p[SYNC_STAGES];
    assign cs_fall  = ~cs_p[LAST] & cs_p[SYNC_STAGES];
    assign cs_lvl   = cs_p[LAST];
    assign si_s     = si_p[LAST];

endmodule

// File: rtl/memcmd_flags.sv
module memcmd_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic set_wel,
    input  logic start_write,
    input  logic write_done,
    output logic wel,
    output logic busy
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wel  <= 1'b0;
            busy <= 1'b0;
        end else begin
            if (start_write) begin
                busy <= 1'b1;
            end else if (write_done && busy) begin
                busy <= 1'b0;
                wel  <= 1'b0;
            end
            if (set_wel) begin
                wel <= 1'b1;
            end
        end
    end

    // R9: completion clears both flags
    p_done_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy && write_done && !start_write |=> !busy && !wel);

    // R11: no enable accepted while a commit runs
    p_no_wel_when_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        set_wel |-> !busy);

    // R8: a commit only starts from an enabled, idle state
    p_start_needs_wel_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start_write |-> wel && !busy);

endmodule

// File: rtl/memcmd_engine.sv
module memcmd_engine
    import memcmd_pkg::*;
#(
    parameter int ADDR_W      = 17,
    parameter int PAGE_W      = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              cs_n,
    input  logic              si,
    output logic              so,
    output logic              so_oe,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_rd_data,
    output logic              mem_wr_en,
    output logic [7:0]        mem_wr_data,
    output logic              commit_req,
    input  logic              commit_done
);

    localparam int SH_W         = ADDR_W - 1;
    localparam int CNT_W        = 5;
    localparam logic [CNT_W-1:0] OPC_LAST  = CNT_W'(7);
    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(31);

    logic sck_rise, sck_fall, cs_rise, cs_fall, cs_lvl, si_s;
    logic wel, busy, set_wel_w, commit_w;

    eng_state_t            state, nxt;
    logic [CNT_W-1:0]      cnt;
    logic [SH_W-1:0]       sh;
    logic [ADDR_W-1:0]     in_word;
    logic                  is_read;
    logic [2:0]            obit;
    logic [2:0]            wbits;
    logic [7:0]            osh;
    logic                  got_byte;
    logic [7:0]            status;

    memcmd_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_rise(cs_rise),
        .cs_fall(cs_fall), .cs_lvl(cs_lvl), .si_s(si_s)
    );

    memcmd_flags u_flags (
        .clk(clk), .rst_n(rst_n), .set_wel(set_wel_w), .start_write(commit_w),
        .write_done(commit_done), .wel(wel), .busy(busy)
    );

    assign in_word   = {sh, si_s};
    assign status    = {6'b0, wel, busy};
    assign set_wel_w = cs_rise && (state == S_WREN_WAIT);
    assign commit_w  = cs_rise && (state == S_WR_DATA) && got_byte && (wbits == 3'd0);
    assign so        = osh[7];

    function automatic eng_state_t decode(input logic [7:0] op, input logic bsy,
                                          input logic en);
        if (bsy) begin
            return (op == OP_RDSR) ? S_ST_DATA : S_IGNORE;
        end
        case (op)
            OP_READ:  return S_ADDR;
            OP_WRITE: return en ? S_ADDR : S_IGNORE;
            OP_WREN:  return S_WREN_WAIT;
            OP_RDSR:  return S_ST_DATA;
            default:  return S_IGNORE;
        endcase
    endfunction

    // next-state logic
    always_comb begin
        nxt = state;
        if (cs_lvl) begin
            nxt = S_IDLE;
        end else if (cs_fall) begin
            nxt = S_OPCODE;
        end else if (sck_rise) begin
            unique case (state)
                S_OPCODE: if (cnt == OPC_LAST)  nxt = decode(in_word[7:0], busy, wel);
                S_ADDR:   if (cnt == ADDR_LAST) nxt = is_read ? S_RD_DATA : S_WR_DATA;
                default:  nxt = state;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            so_oe       <= 1'b0;
            mem_rd_en   <= 1'b0;
            mem_wr_en   <= 1'b0;
            mem_wr_data <= '0;
            mem_addr    <= '0;
            commit_req  <= 1'b0;
            cnt         <= '0;
            sh          <= '0;
            is_read     <= 1'b0;
            obit        <= '0;
            wbits       <= '0;
            osh         <= '0;
            got_byte    <= 1'b0;
        end else begin
            mem_rd_en  <= 1'b0;
            mem_wr_en  <= 1'b0;
            commit_req <= commit_w;
            so_oe      <= ~cs_lvl;
            if (mem_wr_en) begin
                mem_addr[PAGE_W-1:0] <= mem_addr[PAGE_W-1:0] + 1'b1;
            end
            if (cs_fall) begin
                cnt      <= '0;
                obit     <= '0;
                wbits    <= '0;
                got_byte <= 1'b0;
            end else if (!cs_lvl) begin
                if (sck_rise) begin
                    sh  <= in_word[SH_W-1:0];
                    cnt <= cnt + 1'b1;
                    if (state == S_OPCODE && cnt == OPC_LAST) begin
                        is_read <= (in_word[7:0] == OP_READ);
                    end
                    if (state == S_ADDR && cnt == ADDR_LAST) begin
                        mem_addr  <= in_word;
                        mem_rd_en <= is_read;
                    end
                    if (state == S_WR_DATA) begin
                        wbits <= wbits + 1'b1;
                        if (wbits == 3'd7) begin
                            mem_wr_en   <= 1'b1;
                            mem_wr_data <= in_word[7:0];
                            got_byte    <= 1'b1;
                        end
                    end
                end
                if (sck_fall && (state == S_RD_DATA || state == S_ST_DATA)) begin
                    if (obit == 3'd0) begin
                        osh <= (state == S_RD_DATA) ? mem_rd_data : status;
                    end else begin
                        osh <= {osh[6:0], 1'b0};
                    end
                    obit <= obit + 1'b1;
                    if (state == S_RD_DATA && obit == 3'd7) begin
                        mem_addr  <= mem_addr + 1'b1;
                        mem_rd_en <= 1'b1;
                    end
                end
            end
        end
    end

    // R3 / R11: array reads only while streaming a read, never while busy
    p_rd_in_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> (state == S_RD_DATA) && !busy);

    // R10 / R11: a write byte needs WEL and an idle commit path
    p_wr_needs_wel_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> wel && !busy);

    // R8: a commit request coincides with busy
    p_commit_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        commit_req |-> busy);

    // R2: output disabled implies deselected and idle
    p_oe_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !so_oe |-> state == S_IDLE);

endmodule

// File: tb/test_memcmd_engine.sv
module test_memcmd_engine;

    localparam int H = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sck = 1'b0;
    logic        cs_n = 1'b1;
    logic        si = 1'b0;
    logic        so, so_oe, mem_rd_en, mem_wr_en, commit_req;
    logic [16:0] mem_addr;
    logic [7:0]  mem_rd_data = '0;
    logic [7:0]  mem_wr_data;
    logic        commit_done = 1'b0;

    int nchk = 0, nfail = 0, rd_cnt = 0, cm_cnt = 0, ccnt = 0;
    int commit_delay = 3000;
    bit done = 0;

    logic [7:0]  arr[int];
    logic [7:0]  shadow[int];
    logic [7:0]  rq_exp[$];
    string       rq_tag[$];
    logic [24:0] wq[$];
    logic [7:0]  rx_last;
    event        rx_done;

    always #2 clk = ~clk;

    memcmd_engine i_memcmd_engine (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si), .so(so),
        .so_oe(so_oe), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
        .mem_rd_data(mem_rd_data), .mem_wr_en(mem_wr_en),
        .mem_wr_data(mem_wr_data), .commit_req(commit_req),
        .commit_done(commit_done)
    );

    function automatic logic [7:0] fill(input int a);
        return 8'((a * 7) ^ (a >> 9));
    endfunction

    function automatic logic [7:0] expect_at(input int a);
        return shadow.exists(a) ? shadow[a] : fill(a);
    endfunction

    // array and commit models
    always @(posedge clk) begin
        if (mem_rd_en) mem_rd_data <= arr.exists(int'(mem_addr)) ? arr[int'(mem_addr)] : fill(int'(mem_addr));
        if (mem_wr_en) arr[int'(mem_addr)] = mem_wr_data;
        commit_done <= 1'b0;
        if (commit_req) ccnt <= commit_delay;
        else if (ccnt > 0) begin
            ccnt <= ccnt - 1;
            if (ccnt == 1) commit_done <= 1'b1;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // monitors: counters, write scoreboard, read scoreboard
    always @(negedge clk) begin
        if (mem_rd_en) rd_cnt++;
        if (commit_req) cm_cnt++;
        if (mem_wr_en) begin
            if (wq.size() == 0) begin
                check(1'b0, "R10 unexpected write", int'({mem_addr, mem_wr_data}), 0);
            end else begin
                logic [24:0] e;
                e = wq.pop_front();
                check({mem_addr, mem_wr_data} == e, "R7 write item",
                      int'({mem_addr, mem_wr_data}), int'(e));
            end
        end
    end

    always begin
        @(rx_done);
        if (rq_exp.size() > 0) begin
            logic [7:0] e;
            string t;
            e = rq_exp.pop_front();
            t = rq_tag.pop_front();
            check(rx_last == e, t, int'(rx_last), int'(e));
        end
    end

    task automatic sck_bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
        rx = '0;
        for (int i = 7; i > 7 - n; i--) begin
            si = tx[i];
            repeat (H) @(negedge clk);
            sck = 1'b1;
            rx[i] = so;
            repeat (H) @(negedge clk);
            sck = 1'b0;
        end
    endtask

    task automatic xfer(input logic [7:0] tx, input bit chk, input logic [7:0] exp,
                        input string tag);
        logic [7:0] r;
        if (chk) begin
            rq_exp.push_back(exp);
            rq_tag.push_back(tag);
        end
        sck_bits(tx, 8, r);
        rx_last = r;
        ->rx_done;
        @(negedge clk);
    endtask

    task automatic cs_lo();
        @(negedge clk);
        cs_n = 1'b0;
        repeat (H) @(negedge clk);
        check(so_oe == 1'b1, "R2 oe when selected", int'(so_oe), 1);
    endtask

    task automatic cs_hi();
        repeat (H) @(negedge clk);
        cs_n = 1'b1;
        repeat (2 * H) @(negedge clk);
        check(so_oe == 1'b0, "R2 oe when deselected", int'(so_oe), 0);
    endtask

    task automatic send_addr(input logic [23:0] a);
        xfer(a[23:16], 0, 0, "");
        xfer(a[15:8], 0, 0, "");
        xfer(a[7:0], 0, 0, "");
    endtask

    task automatic do_read(input logic [23:0] a, input int n, input string tag);
        cs_lo();
        xfer(8'h03, 0, 0, "");
        send_addr(a);
        for (int i = 0; i < n; i++) begin
            xfer(8'hA5, 1, expect_at(int'((a[16:0] + 17'(i)))), tag);
        end
        cs_hi();
    endtask

    task automatic do_rdsr(input int n, input logic [7:0] exp, input string tag);
        cs_lo();
        xfer(8'h05, 0, 0, "");
        for (int i = 0; i < n; i++) xfer(8'h00, 1, exp, tag);
        cs_hi();
    endtask

    task automatic do_op(input logic [7:0] op);
        cs_lo();
        xfer(op, 0, 0, "");
        cs_hi();
    endtask

    task automatic do_write(input logic [23:0] a, input logic [31:0] d, input int n,
                            input bit ok);
        cs_lo();
        xfer(8'h02, 0, 0, "");
        send_addr(a);
        for (int i = 0; i < n; i++) begin
            logic [7:0]  b;
            logic [16:0] wa;
            b = d[31 - 8*i -: 8];
            wa = {a[16:7], 7'(a[6:0] + 7'(i))};
            if (ok) begin
                wq.push_back({wa, b});
                shadow[int'(wa)] = b;
            end
            xfer(b, 0, 0, "");
        end
        cs_hi();
    endtask

    initial begin
        int rc, cc;
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(so_oe == 0 && mem_rd_en == 0 && mem_wr_en == 0 && commit_req == 0,
              "R1 reset outputs", int'({so_oe, mem_rd_en, mem_wr_en, commit_req}), 0);
        do_rdsr(1, 8'h00, "R1 status after reset");

        // R3: upper address bits ignored; R4: sequential
        do_read(24'hFE0123, 4, "R3 R4 read stream");
        // R4: wrap at top of array
        do_read(24'h01FFFE, 4, "R4 wrap read");

        // R10: write without enable
        cc = cm_cnt;
        do_write(24'h000200, 32'h11223344, 2, 0);
        check(cm_cnt == cc, "R10 no commit", cm_cnt, cc);
        do_rdsr(1, 8'h00, "R10 status unchanged");

        // R5 / R6
        do_op(8'h06);
        do_rdsr(2, 8'h02, "R5 R6 WEL repeated status");

        // R7 / R8: page wrap write with commit
        cc = cm_cnt;
        do_write(24'h00107E, 32'hA1B2C300, 3, 1);
        check(cm_cnt == cc + 1, "R8 commit pulse", cm_cnt, cc + 1);
        do_rdsr(1, 8'h03, "R8 busy status");

        // R11: commands refused while busy
        rc = rd_cnt;
        cs_lo();
        xfer(8'h03, 0, 0, "");
        send_addr(24'h00107E);
        xfer(8'h00, 0, 0, "");
        cs_hi();
        check(rd_cnt == rc, "R11 no read while busy", rd_cnt, rc);
        do_write(24'h000300, 32'h55000000, 1, 0);
        do_rdsr(1, 8'h03, "R11 status still busy");

        // R9: completion clears flags
        repeat (commit_delay + 200) @(negedge clk);
        do_rdsr(1, 8'h00, "R9 flags cleared");
        do_read(24'h00107E, 2, "R7 read back page end");
        do_read(24'h001000, 1, "R7 read back page start");

        // R12: unknown opcode swallows following bytes
        cs_lo();
        xfer(8'hAB, 0, 0, "");
        xfer(8'h06, 0, 0, "");
        xfer(8'h03, 0, 0, "");
        cs_hi();
        do_rdsr(1, 8'h00, "R12 no stray enable");
        do_read(24'h000010, 1, "R12 next command decoded");

        // R13: partial byte aborts the commit
        do_op(8'h06);
        cc = cm_cnt;
        cs_lo();
        xfer(8'h02, 0, 0, "");
        send_addr(24'h000400);
        wq.push_back({17'h00400, 8'h9C});
        shadow[32'h400] = 8'h9C;
        xfer(8'h9C, 0, 0, "");
        begin
            logic [7:0] junk;
            sck_bits(8'hF0, 4, junk);
        end
        cs_hi();
        check(cm_cnt == cc, "R13 no commit on partial byte", cm_cnt, cc);
        check(wq.size() == 0, "R13 whole byte written", wq.size(), 0);
        do_rdsr(1, 8'h02, "R13 WEL kept");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

endmodule